// File: doc/BRIEF.md
# DMA Channel Burst Transfer Engine

This block is the data-moving core of one DMA channel. A single start pulse loads a 3-bit flow code, a source address, a destination address, an increment enable for each side, a transfer width and a transfer count. The flow code sets two things. It says which sides are peripherals that pace the transfer. It also says who ends the transfer: the engine itself, the source peripheral or the destination peripheral.

Data moves in bursts on a simple master bus. Each burst reads a run of beats from the source into a small staging store, then writes the same beats to the destination in the same order. The bus lock is held from the first read to the last write of a burst. Each burst is sized so that no incrementing address crosses a 1 kB boundary. When a burst is done, each peripheral side gets a one-cycle acknowledge. At the end, a done pulse is raised and the final addresses stay visible on the outputs.

Top module: `dma_burst_engine`

## Requirements
- R1: Flow code decode, written as code, direction, party that ends the transfer:
  - 3'b000: memory to memory, engine.
  - 3'b001: memory to peripheral, engine.
  - 3'b010: peripheral to memory, engine.
  - 3'b011: peripheral to peripheral, engine.
  - 3'b100: peripheral to peripheral, destination peripheral.
  - 3'b101: memory to peripheral, destination peripheral.
  - 3'b110: peripheral to memory, source peripheral.
  - 3'b111: peripheral to peripheral, source peripheral.
- R2: When the engine ends the transfer, it stops after exactly the programmed number of destination writes. A count of 0 raises done on the next cycle and makes no bus access.
- R3: When a peripheral ends the transfer, the engine samples that peripheral's last-request line when it accepts a burst. A burst accepted with that line high is the final burst.
- R4: A memory side never waits and never gets an acknowledge. Before each burst, a peripheral side must show its burst-request or last-request line high. One cycle after the final write of each burst, the peripheral side gets a one-cycle acknowledge.
- R5: Width code 0, 1 or 2 means 1, 2 or 4 bytes. The code is shown on `m_size`. An incrementing side advances by that many bytes after each of its beats; a side with increment disabled keeps its address.
- R6: A burst is MAX_BURST beats long, shortened to the transfers still due (only when the engine ends the transfer) and to the beats left before the next 1 kB boundary on each incrementing side.
- R7: A burst is N source reads followed by N destination writes, with data written in read order. `m_lock` stays high from the first read through the last write and drops between bursts.
- R8: `done` is a one-cycle pulse and `busy` is high from start until done. `src_addr_out` and `dst_addr_out` hold the next address of each side after the transfer.
- R9: After reset, `busy`, `done`, `m_valid`, `m_lock`, `src_ack` and `dst_ack` are low.

A beat completes on a rising edge where `m_valid` and `m_ready` are both high. Read data is taken on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the settings and starts a transfer when idle |
| flow_code | input | 3 | Direction and end-of-transfer selection |
| src_addr_in | input | AW | Start source address |
| dst_addr_in | input | AW | Start destination address |
| src_inc | input | 1 | Source address increments |
| dst_inc | input | 1 | Destination address increments |
| xfer_width | input | 2 | Width code: 0 byte, 1 halfword, 2 word |
| xfer_count | input | CW | Transfers to move when the engine ends the transfer |
| src_breq | input | 1 | Source peripheral burst request |
| src_lreq | input | 1 | Source peripheral last-burst request |
| dst_breq | input | 1 | Destination peripheral burst request |
| dst_lreq | input | 1 | Destination peripheral last-burst request |
| src_ack | output | 1 | Source peripheral burst acknowledge |
| dst_ack | output | 1 | Destination peripheral burst acknowledge |
| m_addr | output | AW | Bus address |
| m_write | output | 1 | Bus write (1) or read (0) |
| m_size | output | 2 | Width code of the beat |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| m_valid | output | 1 | Beat requested |
| m_ready | input | 1 | Beat accepted |
| m_lock | output | 1 | Bus lock across a burst |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| src_addr_out | output | AW | Current source address |
| dst_addr_out | output | AW | Current destination address |

## Verification
The assertions assume that:
- Start addresses are aligned to the width.
- The width code is never 3.
- Settings change only while the engine is idle.
- Request lines rise only while the engine is active and stay high until the matching acknowledge.

The stimulus draws aligned addresses, half of them placed a few beats before a 1 kB boundary, and uses only width codes 0 to 2. It raises each request line after a random delay and clears it on the acknowledge. `m_ready` is randomized, so beats stall at arbitrary points, including across the change from reads to writes.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    CTL_DMA = 2'd0,
    CTL_SRC = 2'd1,
    CTL_DST = 2'd2
  } flow_ctl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREQ,
    ST_RD,
    ST_WR,
    ST_ACK
  } eng_state_e;

  typedef struct packed {
    logic      src_periph;
    logic      dst_periph;
    flow_ctl_e ctl;
  } flow_cfg_t;

endpackage

// File: rtl/dma_flow_decode.sv
module dma_flow_decode
  import dma_eng_pkg::*;
(
  input  logic [2:0] code,
  output flow_cfg_t  cfg
);

  // R1: each code picks the paced sides and the party that ends the transfer
  always_comb begin
    cfg = '{src_periph: 1'b0, dst_periph: 1'b0, ctl: CTL_DMA};
    case (code)
      3'b000: ;
      3'b001: cfg.dst_periph = 1'b1;
      3'b010: cfg.src_periph = 1'b1;
      3'b011: begin
        cfg.src_periph = 1'b1;
        cfg.dst_periph = 1'b1;
      end
      3'b100: begin
        cfg.src_periph = 1'b1;
        cfg.dst_periph = 1'b1;
        cfg.ctl        = CTL_DST;
      end
      3'b101: begin
        cfg.dst_periph = 1'b1;
        cfg.ctl        = CTL_DST;
      end
      3'b110: begin
        cfg.src_periph = 1'b1;
        cfg.ctl        = CTL_SRC;
      end
      3'b111: begin
        cfg.src_periph = 1'b1;
        cfg.dst_periph = 1'b1;
        cfg.ctl        = CTL_SRC;
      end
    endcase
  end

endmodule

// File: rtl/dma_burst_sizer.sv
module dma_burst_sizer #(
  parameter int MAX_BURST = 8,
  parameter int BOUNDARY  = 1024,
  parameter int CW        = 16,
  localparam int OFFW     = $clog2(BOUNDARY),
  localparam int RW       = OFFW + 1,
  localparam int BLW      = $clog2(MAX_BURST + 1)
) (
  input  logic [OFFW-1:0] src_off,
  input  logic [OFFW-1:0] dst_off,
  input  logic            src_inc,
  input  logic            dst_inc,
  input  logic [1:0]      width,
  input  logic [CW-1:0]   remaining,
  input  logic            use_count,
  output logic [BLW-1:0]  len
);

  logic [OFFW-1:0] off  [2];
  logic            inc  [2];
  logic [RW-1:0]   room [2];
  logic [31:0]     n;

  assign off[0] = src_off;
  assign off[1] = dst_off;
  assign inc[0] = src_inc;
  assign inc[1] = dst_inc;

  // R6: beats left before the next boundary, per incrementing side
  for (genvar s = 0; s < 2; s++) begin : g_side
    assign room[s] = inc[s] ? ((RW'(BOUNDARY) - {1'b0, off[s]}) >> width)
                            : RW'(MAX_BURST);
  end

  always_comb begin
    n = 32'(MAX_BURST);
    if (32'(room[0]) < n) n = 32'(room[0]);
    if (32'(room[1]) < n) n = 32'(room[1]);
    if (use_count && (32'(remaining) < n)) n = 32'(remaining);
    len = BLW'(n);
  end

endmodule

// File: rtl/dma_burst_engine.sv
module dma_burst_engine
  import dma_eng_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int CW        = 16,
  parameter int MAX_BURST = 8,
  parameter int BOUNDARY  = 1024
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    flow_code,
  input  logic [AW-1:0] src_addr_in,
  input  logic [AW-1:0] dst_addr_in,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [1:0]    xfer_width,
  input  logic [CW-1:0] xfer_count,
  input  logic          src_breq,
  input  logic          src_lreq,
  input  logic          dst_breq,
  input  logic          dst_lreq,
  output logic          src_ack,
  output logic          dst_ack,
  output logic [AW-1:0] m_addr,
  output logic          m_write,
  output logic [1:0]    m_size,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_lock,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_addr_out,
  output logic [AW-1:0] dst_addr_out
);

  localparam int BLW  = $clog2(MAX_BURST + 1);
  localparam int BIW  = $clog2(MAX_BURST);
  localparam int OFFW = $clog2(BOUNDARY);

  eng_state_e    state;
  flow_cfg_t     cfg_in, cfg_q;
  logic          src_inc_q, dst_inc_q;
  logic [1:0]    width_q;
  logic [AW-1:0] src_a, dst_a, step;
  logic [CW-1:0] remain;
  logic [BLW-1:0] blen, burst_len;
  logic [BIW-1:0] beat;
  logic          last_q, done_q;
  logic          src_ok, dst_ok, go, seen_last, finished, beat_last;
  logic [DW-1:0] stage_mem [MAX_BURST];

  dma_flow_decode u_decode (
    .code (flow_code),
    .cfg  (cfg_in)
  );

  dma_burst_sizer #(
    .MAX_BURST (MAX_BURST),
    .BOUNDARY  (BOUNDARY),
    .CW        (CW)
  ) u_sizer (
    .src_off   (src_a[OFFW-1:0]),
    .dst_off   (dst_a[OFFW-1:0]),
    .src_inc   (src_inc_q),
    .dst_inc   (dst_inc_q),
    .width     (width_q),
    .remaining (remain),
    .use_count (cfg_q.ctl == CTL_DMA),
    .len       (burst_len)
  );

  assign step      = AW'(1) << width_q;
  assign src_ok    = !cfg_q.src_periph || src_breq || src_lreq;
  assign dst_ok    = !cfg_q.dst_periph || dst_breq || dst_lreq;
  assign go        = (state == ST_WREQ) && src_ok && dst_ok;
  assign seen_last = ((cfg_q.ctl == CTL_SRC) && src_lreq) ||
                     ((cfg_q.ctl == CTL_DST) && dst_lreq);
  assign finished  = (cfg_q.ctl == CTL_DMA) ? (remain == '0) : last_q;
  assign beat_last = ((BLW'(beat) + BLW'(1)) == blen);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg_q     <= '{src_periph: 1'b0, dst_periph: 1'b0, ctl: CTL_DMA};
      src_inc_q <= 1'b0;
      dst_inc_q <= 1'b0;
      width_q   <= '0;
      src_a     <= '0;
      dst_a     <= '0;
      remain    <= '0;
      blen      <= '0;
      beat      <= '0;
      last_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          cfg_q     <= cfg_in;
          src_inc_q <= src_inc;
          dst_inc_q <= dst_inc;
          width_q   <= xfer_width;
          src_a     <= src_addr_in;
          dst_a     <= dst_addr_in;
          remain    <= xfer_count;
          last_q    <= 1'b0;
          if (cfg_in.ctl == CTL_DMA && xfer_count == '0) done_q <= 1'b1;
          else state <= ST_WREQ;
        end
        ST_WREQ: if (go) begin
          blen   <= burst_len;
          beat   <= '0;
          last_q <= seen_last;
          state  <= ST_RD;
        end
        ST_RD: if (m_ready) begin
          if (src_inc_q) src_a <= src_a + step;
          if (beat_last) begin
            beat  <= '0;
            state <= ST_WR;
          end else begin
            beat <= beat + BIW'(1);
          end
        end
        ST_WR: if (m_ready) begin
          if (dst_inc_q) dst_a <= dst_a + step;
          if (cfg_q.ctl == CTL_DMA) remain <= remain - CW'(1);
          if (beat_last) state <= ST_ACK;
          else beat <= beat + BIW'(1);
        end
        ST_ACK: begin
          if (finished) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            state <= ST_WREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // staging store, written per read beat, read by write beat index
  always_ff @(posedge clk) begin
    if (state == ST_RD && m_ready) stage_mem[beat] <= m_rdata;
  end

  assign m_valid      = (state == ST_RD) || (state == ST_WR);
  assign m_write      = (state == ST_WR);
  assign m_lock       = m_valid;
  assign m_addr       = m_write ? dst_a : src_a;
  assign m_size       = width_q;
  assign m_wdata      = stage_mem[beat];
  assign src_ack      = (state == ST_ACK) && cfg_q.src_periph;
  assign dst_ack      = (state == ST_ACK) && cfg_q.dst_periph;
  assign busy         = (state != ST_IDLE);
  assign done         = done_q;
  assign src_addr_out = src_a;
  assign dst_addr_out = dst_a;

  p_lock_join_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && m_ready && beat_last) |=> (m_lock && m_valid && m_write));

  p_src_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WREQ && cfg_q.src_periph && !src_breq && !src_lreq) |=> (state == ST_WREQ));

  p_dst_wait_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WREQ && cfg_q.dst_periph && !dst_breq && !dst_lreq) |=> (state == ST_WREQ));

  p_mem_nowait_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WREQ && !cfg_q.src_periph && !cfg_q.dst_periph) |=> (state == ST_RD));

  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (src_ack || dst_ack) |=> (!src_ack && !dst_ack));

  p_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
    go |=> (blen != '0));

  p_src_bound_r6: assert property (@(posedge clk) disable iff (rst)
    go |=> (!src_inc_q || (({2'b0, src_a[OFFW-1:0]} + ((OFFW+2)'(blen) << width_q))
                           <= (OFFW+2)'(BOUNDARY))));

  p_dst_bound_r6: assert property (@(posedge clk) disable iff (rst)
    go |=> (!dst_inc_q || (({2'b0, dst_a[OFFW-1:0]} + ((OFFW+2)'(blen) << width_q))
                           <= (OFFW+2)'(BOUNDARY))));

  p_src_step_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && m_ready) |=>
      (src_a == ($past(src_a) + ($past(src_inc_q) ? step : '0))));

  p_count_end_r2: assert property (@(posedge clk) disable iff (rst)
    (done && cfg_q.ctl == CTL_DMA) |-> (remain == '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/test_dma_burst_engine.sv
module test_dma_burst_engine;

  localparam int AW = 32, DW = 32, CW = 16, MAXB = 8, BND = 1024, NX = 256;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] flow_code = '0;
  logic [AW-1:0] src_addr_in = '0, dst_addr_in = '0;
  logic src_inc = 1'b0, dst_inc = 1'b0;
  logic [1:0] xfer_width = '0;
  logic [CW-1:0] xfer_count = '0;
  logic src_breq = 1'b0, src_lreq = 1'b0, dst_breq = 1'b0, dst_lreq = 1'b0;
  logic src_ack, dst_ack, m_write, m_valid, m_lock, busy, done;
  logic m_ready = 1'b0;
  logic [AW-1:0] m_addr, src_addr_out, dst_addr_out;
  logic [1:0] m_size;
  logic [DW-1:0] m_wdata, m_rdata = '0;

  dma_burst_engine #(.AW(AW), .DW(DW), .CW(CW), .MAX_BURST(MAXB), .BOUNDARY(BND)) i_dma_burst_engine (
    .clk(clk), .rst(rst), .start(start), .flow_code(flow_code),
    .src_addr_in(src_addr_in), .dst_addr_in(dst_addr_in),
    .src_inc(src_inc), .dst_inc(dst_inc), .xfer_width(xfer_width), .xfer_count(xfer_count),
    .src_breq(src_breq), .src_lreq(src_lreq), .dst_breq(dst_breq), .dst_lreq(dst_lreq),
    .src_ack(src_ack), .dst_ack(dst_ack), .m_addr(m_addr), .m_write(m_write),
    .m_size(m_size), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_valid(m_valid),
    .m_ready(m_ready), .m_lock(m_lock), .busy(busy), .done(done),
    .src_addr_out(src_addr_out), .dst_addr_out(dst_addr_out));

  always #10 clk = ~clk;

  int total = 0, bad = 0;

  // observed and expected beat lists
  logic          obs_w [NX];
  logic [AW-1:0] obs_a [NX];
  logic [DW-1:0] obs_d [NX];
  logic          exp_w [NX];
  logic [AW-1:0] exp_a [NX];
  logic [DW-1:0] exp_d [NX];
  int obs_n, exp_n, exp_bursts, size_bad;
  logic [AW-1:0] exp_sa_fin, exp_da_fin;

  // monitor counters and peripheral state
  int done_cnt, sack_cnt, dack_cnt, lock_falls, req_viol;
  logic prev_lock = 1'b0;
  logic job_on = 1'b0, j_sp = 1'b0, j_dp = 1'b0;
  int j_ctl = 0, j_nb = 0;
  logic [1:0] j_w = '0;

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // bus, peripheral and event monitor, all at the falling edge
  always @(negedge clk) begin
    logic rdy;
    rdy = ($urandom_range(0, 3) != 0);
    m_ready = rdy;
    m_rdata = mem_f(m_addr);
    if (m_valid && rdy && obs_n < NX) begin
      obs_w[obs_n] = m_write;
      obs_a[obs_n] = m_addr;
      obs_d[obs_n] = m_write ? m_wdata : '0;
      if (m_size != j_w) size_bad++;
      obs_n++;
    end
    if (!prev_lock && m_lock && ((j_sp && !src_breq && !src_lreq) ||
                                 (j_dp && !dst_breq && !dst_lreq))) req_viol++;
    if (prev_lock && !m_lock) lock_falls++;
    prev_lock = m_lock;
    if (done) done_cnt++;
    if (src_ack) begin
      sack_cnt++; src_breq = 1'b0; src_lreq = 1'b0;
    end else if (job_on && j_sp && !src_breq && !src_lreq && sack_cnt < exp_bursts &&
                 $urandom_range(0, 1) == 1) begin
      if (j_ctl == 1 && sack_cnt == j_nb - 1) src_lreq = 1'b1; else src_breq = 1'b1;
    end
    if (dst_ack) begin
      dack_cnt++; dst_breq = 1'b0; dst_lreq = 1'b0;
    end else if (job_on && j_dp && !dst_breq && !dst_lreq && dack_cnt < exp_bursts &&
                 $urandom_range(0, 1) == 1) begin
      if (j_ctl == 2 && dack_cnt == j_nb - 1) dst_lreq = 1'b1; else dst_breq = 1'b1;
    end
  end

  // reference model of the burst sequence
  task automatic build_expected(input logic [AW-1:0] sa0, input logic [AW-1:0] da0,
                                input logic si, input logic di, input logic [1:0] w,
                                input int cnt, input int ctl, input int nb);
    logic [AW-1:0] sa, da, st;
    int rem, n, room;
    sa = sa0; da = da0; rem = cnt; exp_n = 0; exp_bursts = 0;
    st = AW'(1) << w;
    forever begin
      if (ctl == 0 && rem == 0) break;
      if (ctl != 0 && exp_bursts == nb) break;
      n = MAXB;
      if (si) begin room = (BND - int'(sa % BND)) >> w; if (room < n) n = room; end
      if (di) begin room = (BND - int'(da % BND)) >> w; if (room < n) n = room; end
      if (ctl == 0 && rem < n) n = rem;
      for (int i = 0; i < n; i++) begin
        exp_w[exp_n + i] = 1'b0;
        exp_a[exp_n + i] = si ? sa + AW'(i) * st : sa;
        exp_d[exp_n + i] = '0;
        exp_w[exp_n + n + i] = 1'b1;
        exp_a[exp_n + n + i] = di ? da + AW'(i) * st : da;
        exp_d[exp_n + n + i] = mem_f(exp_a[exp_n + i]);
      end
      exp_n += 2 * n;
      if (si) sa = sa + AW'(n) * st;
      if (di) da = da + AW'(n) * st;
      rem -= n;
      exp_bursts++;
    end
    exp_sa_fin = sa; exp_da_fin = da;
  endtask

  task automatic run_job(input logic [2:0] code, input logic [AW-1:0] sa, input logic [AW-1:0] da,
                         input logic si, input logic di, input logic [1:0] w,
                         input int cnt, input int nb);
    int ctl, waitc, mism;
    bit sp, dp;
    sp = (code != 3'b000) && (code != 3'b001) && (code != 3'b101);
    dp = (code != 3'b000) && (code != 3'b010) && (code != 3'b110);
    ctl = (code == 3'b100 || code == 3'b101) ? 2 : (code == 3'b110 || code == 3'b111) ? 1 : 0;
    @(negedge clk); #1;
    build_expected(sa, da, si, di, w, cnt, ctl, nb);
    obs_n = 0; done_cnt = 0; sack_cnt = 0; dack_cnt = 0; lock_falls = 0;
    req_viol = 0; size_bad = 0;
    j_sp = sp; j_dp = dp; j_ctl = ctl; j_nb = nb; j_w = w;
    flow_code = code; src_addr_in = sa; dst_addr_in = da; src_inc = si; dst_inc = di;
    xfer_width = w; xfer_count = CW'(cnt); start = 1'b1; job_on = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    check(busy == (ctl != 0 || cnt != 0), "R8", "busy after start", busy, (ctl != 0 || cnt != 0));
    waitc = 0;
    while (done_cnt == 0 && waitc < 4000) begin
      @(negedge clk); #1;
      waitc++;
    end
    check(done_cnt == 1, (ctl == 0) ? "R2" : "R3", "done reached", done_cnt, 1);
    check(obs_n == exp_n, "R6", "beat count", obs_n, exp_n);
    mism = 0;
    for (int i = 0; i < exp_n && i < obs_n; i++)
      if (obs_w[i] != exp_w[i] || obs_a[i] != exp_a[i] || obs_d[i] != exp_d[i]) mism++;
    check(mism == 0, "R7", "beat order/address/data mismatches", mism, 0);
    check(size_bad == 0, "R5", "m_size mismatches", size_bad, 0);
    check(src_addr_out == exp_sa_fin, "R5", "final source address", src_addr_out, exp_sa_fin);
    check(dst_addr_out == exp_da_fin, "R8", "final destination address", dst_addr_out, exp_da_fin);
    check(sack_cnt == (sp ? exp_bursts : 0), "R1", "source acks", sack_cnt, sp ? exp_bursts : 0);
    check(dack_cnt == (dp ? exp_bursts : 0), "R4", "destination acks", dack_cnt, dp ? exp_bursts : 0);
    check(lock_falls == exp_bursts, "R7", "lock spans per burst", lock_falls, exp_bursts);
    check(req_viol == 0, "R4", "burst began without request", req_viol, 0);
    @(negedge clk); #1;
    check(done_cnt == 1 && !done && !busy, "R8", "single done pulse then idle",
          {done_cnt[7:0], done, busy}, {8'd1, 2'b00});
    job_on = 1'b0;
    src_breq = 1'b0; src_lreq = 1'b0; dst_breq = 1'b0; dst_lreq = 1'b0;
  endtask

  function automatic logic [AW-1:0] pick_addr(input logic [1:0] w);
    logic [AW-1:0] a;
    a = {$urandom_range(0, 255), 10'h000} & ~(AW'(1) << 31);
    if ($urandom_range(0, 1) == 1) a = a + AW'(BND) - (AW'($urandom_range(0, 12)) << w);
    else a = a + (AW'($urandom_range(0, 200)) << w);
    return a;
  endfunction

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL R2 watchdog expired: actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    #1;
    check(!busy && !done && !m_valid && !m_lock && !src_ack && !dst_ack, "R9", "reset outputs",
          {busy, done, m_valid, m_lock, src_ack, dst_ack}, 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check(!busy && !m_valid, "R9", "idle after reset", {busy, m_valid}, 0);

    // directed corner cases
    run_job(3'b000, 32'h1000, 32'h2000, 1, 1, 2'd2, 20, 1);  // R2 plain copy
    run_job(3'b000, 32'h13F8, 32'h2000, 1, 1, 2'd2, 10, 1);  // R6 source two beats from boundary
    run_job(3'b000, 32'h3000, 32'h47FA, 1, 1, 2'd1, 9, 1);   // R6 destination three halfwords from boundary
    run_job(3'b011, 32'h5000, 32'h6000, 0, 0, 2'd0, 11, 1);  // R5 fixed addresses both sides
    run_job(3'b000, 32'h7000, 32'h8000, 1, 1, 2'd2, 0, 1);   // R2 zero count
    run_job(3'b000, 32'h7004, 32'h8008, 1, 1, 2'd0, 1, 1);   // R2 single transfer
    run_job(3'b110, 32'h9000, 32'hA000, 0, 1, 2'd2, 0, 1);   // R3 last request on first burst
    run_job(3'b100, 32'hB3FC, 32'hC000, 1, 0, 2'd1, 0, 3);   // R3 destination ends, source crosses
    for (int c = 0; c < 8; c++)                                // R1 every code
      run_job(3'(c), 32'h2_0000 + 32'(c) * 32'h1000, 32'h3_0000, 1, 1, 2'd2, 13, 2);

    // constrained random mix
    for (int k = 0; k < 60; k++) begin
      logic [1:0] w;
      w = 2'($urandom_range(0, 2));
      run_job(3'($urandom_range(0, 7)), pick_addr(w), pick_addr(w) | (AW'(1) << 30),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), w,
              $urandom_range(1, 40), $urandom_range(1, 4));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule